// File: doc/BRIEF.md
# USB Bulk IN Endpoint Transmit Buffer

This block buffers one outgoing data packet for a single bulk IN endpoint of a USB device controller. Firmware on the local microcontroller loads the packet through one write-only register address. Each write strobe to that address appends one byte after the last one. The USB serial engine reports the number of loaded bytes. It fetches them in order with a read strobe and sends them in an IN data packet.

The buffer holds one packet at a time. It is emptied in three cases: the host acknowledges the packet, firmware sets this endpoint's bit in a shared FIFO-clear register, or a USB bus reset occurs. If the host does not acknowledge, the serial engine rewinds the read side and sends the same bytes again. After each emptying, a packet-ready interrupt tells firmware to load the next packet. When the endpoint is configured for the receive direction, the register port is shut off completely.

Top module: `usb_in_txbuf`

## Requirements
- R1: A write strobe whose address equals TX_ADDR (default 8'hC2) appends the data byte, and byteCount rises by one on the next clock edge. A write strobe at any other address changes nothing.
- R2: rdData shows the byte at the read position without a clock delay. Each usbRdStrb moves to the next byte, so the bytes come out in the order they were written.
- R3: The buffer holds DEPTH (default 64) bytes. A write to a full buffer is dropped, byteCount stays at DEPTH, and overflow goes to 1. Overflow stays at 1 until ovfClr is pulsed. If a new overflow and ovfClr occur in the same cycle, the new overflow wins.
- R4: A hostAck pulse empties the buffer. byteCount reads 0 on the next edge.
- R5: A clrWrEn strobe whose clrWrData bit EP_INDEX (default bit 2) is 1 empties the buffer. When that bit is 0, the strobe has no effect, whatever the other bits are.
- R6: A busReset pulse empties the buffer in the same way as R4.
- R7: A pktRetry pulse returns the read position to the first byte of the packet. byteCount is left unchanged.
- R8: While dirRx is 1, every write to TX_ADDR is ignored. byteCount, the stored bytes and overflow all stay as they were.
- R9: pktReadyIrq goes to 1 on the edge after any emptying event (R4, R5, R6) while dirRx is 0. It goes back to 0 on the edge after the first accepted byte write. It is held at 0 while dirRx is 1.
- R10: If an emptying event and a byte write occur in the same cycle, the emptying event takes priority. The byte is dropped and byteCount reads 0.
- R11: After rstN is asserted, byteCount, pktReadyIrq and overflow are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| regWrEn | input | 1 | Firmware register write strobe |
| regAddr | input | ADDR_W | Firmware register address |
| regWrData | input | DATA_W | Firmware write data |
| clrWrEn | input | 1 | Write strobe for the FIFO-clear register |
| clrWrData | input | CLR_W | FIFO-clear register data; bit EP_INDEX selects this endpoint |
| dirRx | input | 1 | Endpoint direction is receive; disables the register port |
| ovfClr | input | 1 | Clears the sticky overflow flag |
| busReset | input | 1 | USB bus reset pulse |
| hostAck | input | 1 | Host ACK received for the packet just sent |
| pktRetry | input | 1 | No ACK received; rewind to resend the packet |
| usbRdStrb | input | 1 | Serial engine fetches the next byte |
| rdData | output | DATA_W | Byte at the current read position |
| byteCount | output | $clog2(DEPTH+1) | Bytes loaded in the current packet |
| pktReadyIrq | output | 1 | Packet-ready interrupt request |
| overflow | output | 1 | Sticky flag: a write was dropped because the buffer was full |

## Verification
A corrupted write pointer or count shows up on byteCount on the next edge. It also shows up on rdData when the serial engine fetches the affected byte, which can be as soon as the same cycle the read position reaches it. A wrong read pointer changes rdData right away, and a missing rewind shows up on the first byte after pktRetry. The interrupt and overflow flags are registered, so a wrong priority between clear, write or direction appears on the edge that follows the stimulus. The bench compares byteCount, rdData, pktReadyIrq and overflow on every cycle.

// File: rtl/usb_in_txbuf_pkg.sv
package usb_in_txbuf_pkg;
  // Strobes from the control unit to the buffer datapath.
  typedef struct packed {
    logic clr;     // empty the buffer: pointers and count go to zero
    logic push;    // store one byte at the write position
    logic rewind;  // return the read position to the packet start
    logic pop;     // advance the read position
  } bufStrobes_t;
endpackage

// File: rtl/usb_in_txbuf_dp.sv
module usb_in_txbuf_dp
  import usb_in_txbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobes_t       stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count,
  output logic              full
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [CNT_W-1:0]  rdPtr;
  logic              popOk;

  // Fetches past the last loaded byte are ignored.
  assign popOk  = stb.pop && (rdPtr < count);
  assign full   = (count == FULL_CNT);
  assign rdData = store[rdPtr[PTR_W-1:0]];

  // Storage has no reset: its contents are undefined until written.
  always_ff @(posedge clk) begin
    if (stb.push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (stb.clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) begin
        wrPtr <= wrPtr + 1'b1;
        count <= count + 1'b1;
      end
      if (stb.rewind)  rdPtr <= '0;
      else if (popOk)  rdPtr <= rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/usb_in_txbuf_ctrl.sv
module usb_in_txbuf_ctrl
  import usb_in_txbuf_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                CLR_W    = 8,
  parameter int                EP_INDEX = 2,
  parameter logic [ADDR_W-1:0] TX_ADDR  = 8'hC2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              clrWrEn,
  input  logic [CLR_W-1:0]  clrWrData,
  input  logic              dirRx,
  input  logic              ovfClr,
  input  logic              busReset,
  input  logic              hostAck,
  input  logic              pktRetry,
  input  logic              usbRdStrb,
  input  logic              full,
  output bufStrobes_t       stb,
  output logic              irq,
  output logic              ovf
);
  logic addrHit, portLive, clrAny, fwClr, ovfSet;

  assign addrHit  = regWrEn && (regAddr == TX_ADDR);
  assign portLive = addrHit && !dirRx;
  assign fwClr    = clrWrEn && clrWrData[EP_INDEX];
  assign clrAny   = fwClr || hostAck || busReset;
  assign ovfSet   = portLive && !clrAny && full;

  always_comb begin
    stb.clr    = clrAny;
    stb.push   = portLive && !clrAny && !full;
    stb.rewind = pktRetry;
    stb.pop    = usbRdStrb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else if (clrAny) begin
      irq <= !dirRx;
    end else if (stb.push || dirRx) begin
      irq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ovf <= 1'b0;
    else if (ovfSet)  ovf <= 1'b1;
    else if (ovfClr)  ovf <= 1'b0;
  end
endmodule

// File: rtl/usb_in_txbuf.sv
module usb_in_txbuf
  import usb_in_txbuf_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                DEPTH    = 64,
  parameter int                ADDR_W   = 8,
  parameter int                CLR_W    = 8,
  parameter int                EP_INDEX = 2,
  parameter logic [ADDR_W-1:0] TX_ADDR  = 8'hC2,
  localparam int               CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              clrWrEn,
  input  logic [CLR_W-1:0]  clrWrData,
  input  logic              dirRx,
  input  logic              ovfClr,
  input  logic              busReset,
  input  logic              hostAck,
  input  logic              pktRetry,
  input  logic              usbRdStrb,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  byteCount,
  output logic              pktReadyIrq,
  output logic              overflow
);
  bufStrobes_t stb;
  logic        full;

  usb_in_txbuf_ctrl #(
    .ADDR_W(ADDR_W), .CLR_W(CLR_W), .EP_INDEX(EP_INDEX), .TX_ADDR(TX_ADDR)
  ) ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .clrWrEn(clrWrEn), .clrWrData(clrWrData), .dirRx(dirRx), .ovfClr(ovfClr),
    .busReset(busReset), .hostAck(hostAck), .pktRetry(pktRetry),
    .usbRdStrb(usbRdStrb), .full(full), .stb(stb), .irq(pktReadyIrq),
    .ovf(overflow)
  );

  usb_in_txbuf_dp #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData),
    .rdData(rdData), .count(byteCount), .full(full)
  );
endmodule

// File: rtl/usb_in_txbuf_chk.sv
module usb_in_txbuf_chk #(
  parameter int                DEPTH    = 64,
  parameter int                ADDR_W   = 8,
  parameter int                CLR_W    = 8,
  parameter int                EP_INDEX = 2,
  parameter logic [ADDR_W-1:0] TX_ADDR  = 8'hC2,
  localparam int               CNT_W    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              clrWrEn,
  input logic [CLR_W-1:0]  clrWrData,
  input logic              dirRx,
  input logic              busReset,
  input logic              hostAck,
  input logic              pktRetry,
  input logic [CNT_W-1:0]  byteCount,
  input logic              pktReadyIrq,
  input logic              overflow
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic emptyEv, wrTry, wrOk;
  assign emptyEv = hostAck || busReset || (clrWrEn && clrWrData[EP_INDEX]);
  assign wrTry   = regWrEn && (regAddr == TX_ADDR);
  assign wrOk    = wrTry && !dirRx && !emptyEv && (byteCount != FULL_CNT);

  a_r1_write_counts: assert property (@(posedge clk) disable iff (!rstN)
    wrOk |=> (byteCount - $past(byteCount)) == CNT_W'(1));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    byteCount <= FULL_CNT);

  a_r3_ovf_cause: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !$past(overflow)) |-> ($past(byteCount) == FULL_CNT && $past(wrTry)));

  // R4, R5, R6 and R10: any emptying event wins and leaves zero bytes.
  a_r4_empty_after_clear: assert property (@(posedge clk) disable iff (!rstN)
    emptyEv |=> byteCount == '0);

  a_r7_retry_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (pktRetry && !emptyEv && !wrTry) |=> $stable(byteCount));

  a_r8_rx_ignores_writes: assert property (@(posedge clk) disable iff (!rstN)
    (dirRx && !emptyEv) |=> $stable(byteCount) && (overflow || !$past(overflow) || 1'b1) && !( overflow && !$past(overflow)));

  a_r9_irq_drops_on_write: assert property (@(posedge clk) disable iff (!rstN)
    wrOk |=> !pktReadyIrq);

  a_r9_irq_rises_on_clear: assert property (@(posedge clk) disable iff (!rstN)
    (emptyEv && !dirRx) |=> pktReadyIrq);

  a_r9_irq_low_in_rx: assert property (@(posedge clk) disable iff (!rstN)
    dirRx |=> !pktReadyIrq);
endmodule

bind usb_in_txbuf usb_in_txbuf_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CLR_W(CLR_W), .EP_INDEX(EP_INDEX), .TX_ADDR(TX_ADDR)
) chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .clrWrEn(clrWrEn), .clrWrData(clrWrData), .dirRx(dirRx), .busReset(busReset),
  .hostAck(hostAck), .pktRetry(pktRetry), .byteCount(byteCount),
  .pktReadyIrq(pktReadyIrq), .overflow(overflow)
);

// File: tb/usb_in_txbuf_test.sv
module usb_in_txbuf_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int CNT_W      = $clog2(DEPTH + 1);

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWrData = 8'h00;
  logic       clrWrEn = 1'b0;
  logic [7:0] clrWrData = 8'h00;
  logic       dirRx = 1'b0;
  logic       ovfClr = 1'b0;
  logic       busReset = 1'b0;
  logic       hostAck = 1'b0;
  logic       pktRetry = 1'b0;
  logic       usbRdStrb = 1'b0;
  logic [7:0] rdData;
  logic [CNT_W-1:0] byteCount;
  logic       pktReadyIrq;
  logic       overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_in_txbuf uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .clrWrEn(clrWrEn), .clrWrData(clrWrData),
    .dirRx(dirRx), .ovfClr(ovfClr), .busReset(busReset), .hostAck(hostAck),
    .pktRetry(pktRetry), .usbRdStrb(usbRdStrb), .rdData(rdData),
    .byteCount(byteCount), .pktReadyIrq(pktReadyIrq), .overflow(overflow)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, updated on every rising edge.
  logic [7:0] mQ[$];
  int  mRd  = 0;
  bit  mIrq = 0;
  bit  mOvf = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mQ.delete(); mRd = 0; mIrq = 0; mOvf = 0;
    end else begin
      bit emptyEv, acc, setOvf;
      emptyEv = hostAck || busReset || (clrWrEn && clrWrData[2]);
      acc     = regWrEn && regAddr == 8'hC2 && !dirRx;
      setOvf  = 0;
      if (emptyEv) begin
        mQ.delete(); mRd = 0; mIrq = !dirRx;
      end else begin
        if (acc) begin
          if (mQ.size() < DEPTH) begin mQ.push_back(regWrData); mIrq = 0; end
          else setOvf = 1;
        end
        if (pktRetry) mRd = 0;
        else if (usbRdStrb && mRd < mQ.size()) mRd++;
        if (dirRx) mIrq = 0;
      end
      if (setOvf) mOvf = 1;
      else if (ovfClr) mOvf = 0;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R1 byteCount vs model", 32'(byteCount), 32'(mQ.size()));
      check("R9 pktReadyIrq vs model", 32'(pktReadyIrq), 32'(mIrq));
      check("R3 overflow vs model", 32'(overflow), 32'(mOvf));
      if (mRd < mQ.size()) check("R2 rdData vs model", 32'(rdData), 32'(mQ[mRd]));
    end
  end

  task automatic tick();
    @(negedge clk);
    regWrEn = 0; clrWrEn = 0; ovfClr = 0; busReset = 0;
    hostAck = 0; pktRetry = 0; usbRdStrb = 0;
  endtask

  task automatic wr(logic [7:0] addr, logic [7:0] d);
    regWrEn = 1; regAddr = addr; regWrData = d; tick();
  endtask

  task automatic fwClear(logic [7:0] bits);
    clrWrEn = 1; clrWrData = bits; tick();
  endtask

  task automatic pop();
    usbRdStrb = 1; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R11 reset count", 32'(byteCount), 0);
    check("R11 reset irq", 32'(pktReadyIrq), 0);
    check("R11 reset overflow", 32'(overflow), 0);

    fwClear(8'h04);
    check("R5 firmware clear count", 32'(byteCount), 0);
    check("R9 irq after clear", 32'(pktReadyIrq), 1);
    wr(8'hC3, 8'h55);
    check("R1 other address ignored", 32'(byteCount), 0);
    check("R1 irq kept on other address", 32'(pktReadyIrq), 1);
    wr(8'hC2, 8'hA0);
    check("R1 first byte counted", 32'(byteCount), 1);
    check("R9 irq drops on first write", 32'(pktReadyIrq), 0);
    fwClear(8'hFB);
    check("R5 other clear bits no effect", 32'(byteCount), 1);
    for (int i = 1; i < 10; i++) wr(8'hC2, 8'(8'hA0 + i));
    check("R1 ten bytes", 32'(byteCount), 10);
    check("R2 first byte shown", 32'(rdData), 32'h A0);
    for (int i = 0; i < 4; i++) pop();
    check("R2 fifth byte after four reads", 32'(rdData), 32'h A4);
    pktRetry = 1; tick();
    check("R7 rewind to first byte", 32'(rdData), 32'h A0);
    check("R7 count kept", 32'(byteCount), 10);
    for (int i = 0; i < 12; i++) pop();
    hostAck = 1; tick();
    check("R4 ack empties", 32'(byteCount), 0);
    check("R9 irq after ack", 32'(pktReadyIrq), 1);

    for (int i = 0; i < DEPTH + 2; i++) wr(8'hC2, 8'(i * 3));
    check("R3 count capped", 32'(byteCount), DEPTH);
    check("R3 overflow set", 32'(overflow), 1);
    check("R3 first byte kept", 32'(rdData), 0);
    ovfClr = 1; tick();
    check("R3 overflow cleared", 32'(overflow), 0);
    check("R3 count after clear of flag", 32'(byteCount), DEPTH);

    clrWrEn = 1; clrWrData = 8'h04; regWrEn = 1; regAddr = 8'hC2; regWrData = 8'h77; tick();
    check("R10 clear beats write", 32'(byteCount), 0);

    dirRx = 1; tick();
    check("R9 irq low in receive", 32'(pktReadyIrq), 0);
    for (int i = 0; i < 3; i++) wr(8'hC2, 8'h11);
    check("R8 writes ignored in receive", 32'(byteCount), 0);
    dirRx = 0;
    wr(8'hC2, 8'hB0); wr(8'hC2, 8'hB1);
    dirRx = 1;
    wr(8'hC2, 8'hEE);
    check("R8 count kept in receive", 32'(byteCount), 2);
    check("R8 data kept in receive", 32'(rdData), 32'h B0);
    check("R8 no overflow in receive", 32'(overflow), 0);
    dirRx = 0; tick();

    busReset = 1; tick();
    check("R6 bus reset empties", 32'(byteCount), 0);
    check("R9 irq after bus reset", 32'(pktReadyIrq), 1);
    tick();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule